// File: doc/BRIEF.md
# Lane Buffer Address Generator

This block turns a buffer resource description and per-lane operands into one memory address per active lane of a 64-lane vector instruction. A pulse on `start_i` begins a pass. The block then walks the lanes in ascending order, one lane per clock. For each lane whose execute bit is set, it emits the lane number and its byte address on a valid strobe and records whether the lane falls outside the buffer.

The address is formed from four parts: the descriptor base, the scalar offset, the per-lane offset (vector offset plus the instruction immediate), and a per-lane index (vector index, optionally plus the lane number). The index and offset are combined in one of two ways. In linear mode, the stride multiplies the index. In swizzled mode, the index and the offset are each split at power-of-two boundaries and interleaved. The bounds test follows one of two rules, selected by the stride and the swizzle enable.

When the pass ends, `done_o` pulses. At that point `oob_mask_o` holds the out-of-range lanes and `eff_mask_o` holds the execute mask with those lanes removed, ready for the access. The incoming execute mask is never altered, so the original mask stays available once the access completes.

Top module: `lane_addr_gen`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `addr_valid_o` are 0 and `oob_mask_o` is all zero.
- R2: A start accepted on an idle clock edge E makes `busy_o` high from E+1 through E+64. The result for lane k is presented after edge E+k+1. `done_o` is high for exactly the one cycle after edge E+64.
- R3: The effective stride is `(dfmt_i << 14) + stride_i` when `tid_en_i` is 1, and `stride_i` otherwise.
- R4: The lane index is the lane's 32-bit field of `vec_idx_i` (bits 32k+31..32k), plus the lane number k when `tid_en_i` is 1. The lane offset is the lane's field of `vec_off_i` plus `inst_off_i`.
- R5: With `swz_en_i` = 0, the address is base + soff + offset + stride × index, computed in 64 bits.
- R6: When the stride is 0 or `swz_en_i` = 0, a lane is out of bounds when offset + stride × index ≥ nrec − soff. If soff > nrec, the limit is taken as 0 and every evaluated lane is out of bounds.
- R7: When the stride is non-zero and `swz_en_i` = 1, a lane is out of bounds when index ≥ nrec or offset ≥ stride.
- R8: With `swz_en_i` = 1, let I = 8 << `istr_code_i` and S = 2 << `esz_code_i`. The address is base + soff + ((index / I) × stride + (offset / S) × S) × I + (index mod I) × S + offset mod S.
- R9: A lane whose execute bit is 0 produces no valid strobe, a zero address, and a 0 in `oob_mask_o`.
- R10: While `done_o` is high, `eff_mask_o` equals `exec_mask_i` with the `oob_mask_o` lanes cleared.
- R11: A `start_i` pulse while `busy_o` is high is ignored: the pass, its timing and its results continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a pass (taken when idle) |
| base_i | input | 48 | Buffer base address |
| stride_i | input | 14 | Record stride field |
| nrec_i | input | 32 | Record count |
| tid_en_i | input | 1 | Add lane number to index and extend stride |
| dfmt_i | input | 4 | Format field, upper stride bits when tid_en_i is set |
| swz_en_i | input | 1 | Swizzled addressing enable |
| istr_code_i | input | 2 | Index interleave code (8 << code) |
| esz_code_i | input | 2 | Element size code (2 << code) |
| soff_i | input | 32 | Scalar offset |
| inst_off_i | input | 12 | Instruction immediate offset |
| vec_off_i | input | 2048 | Per-lane offsets, 32 bits per lane |
| vec_idx_i | input | 2048 | Per-lane indices, 32 bits per lane |
| exec_mask_i | input | 64 | Execute mask |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| addr_valid_o | output | 1 | Address for addr_lane_o is valid |
| addr_lane_o | output | 6 | Lane of the presented address |
| addr_o | output | 64 | Lane byte address |
| oob_mask_o | output | 64 | Out-of-bounds lanes of the pass |
| eff_mask_o | output | 64 | Execute mask minus out-of-bounds lanes |

## Verification
The assertions assume that every descriptor field, the per-lane vectors and the execute mask stay constant from the accepted start until `done_o`. The valid-to-execute-bit property and the mask-subset property compare live inputs against registered results, so they depend on this. The stimulus changes these inputs only between passes, while the block is idle. The one deliberate exception is a repeated `start_i` pulse in the middle of a pass, which is allowed to vary.

// File: rtl/lag_pkg.sv
package lag_pkg;

    localparam int BASE_W   = 48;
    localparam int STRIDE_W = 14;
    localparam int DFMT_W   = 4;
    localparam int NREC_W   = 32;
    localparam int WORD_W   = 32;
    localparam int IMM_W    = 12;
    localparam int CALC_W   = 64;
    localparam int DFMT_SH  = 14;

    typedef struct packed {
        logic [BASE_W-1:0]   base;
        logic [STRIDE_W-1:0] stride;
        logic [NREC_W-1:0]   nrec;
        logic                tid_en;
        logic [DFMT_W-1:0]   dfmt;
        logic                swz_en;
        logic [1:0]          istr_code;
        logic [1:0]          esz_code;
    } rsrc_t;

    typedef struct packed {
        logic              oob;
        logic [CALC_W-1:0] addr;
    } lane_res_t;

    function automatic logic [CALC_W-1:0] eff_stride(input rsrc_t d);
        logic [CALC_W-1:0] s;
        s = CALC_W'(d.stride);
        if (d.tid_en)
            s = s + (CALC_W'(d.dfmt) << DFMT_SH);
        return s;
    endfunction

endpackage

// File: rtl/lag_seq.sv
module lag_seq #(
    parameter int LANES  = 64,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              busy_o,
    output logic [LANE_W-1:0] lane_o,
    output logic              done_o
);
    logic last;

    assign last = (lane_o == LANE_W'(LANES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            lane_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= busy_o && last;
            if (!busy_o) begin
                lane_o <= '0;
                if (start_i)
                    busy_o <= 1'b1;
            end else if (last) begin
                busy_o <= 1'b0;
            end else begin
                lane_o <= lane_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lag_lane_calc.sv
module lag_lane_calc
    import lag_pkg::*;
#(
    parameter int LANES  = 64,
    localparam int LANE_W = $clog2(LANES)
) (
    input  rsrc_t              rsrc_i,
    input  logic [LANE_W-1:0]  lane_i,
    input  logic [WORD_W-1:0]  voff_i,
    input  logic [WORD_W-1:0]  vidx_i,
    input  logic [WORD_W-1:0]  soff_i,
    input  logic [IMM_W-1:0]   imm_i,
    output lane_res_t          res_o
);
    logic [CALC_W-1:0] stride, idx, off, lin_term, limit;
    logic [CALC_W-1:0] idx_hi, idx_lo, off_hi_al, off_lo, swz_term;
    logic [CALC_W-1:0] idx_mask, off_mask, start_addr;
    logic [2:0]        ish;
    logic [1:0]        esh;
    logic              oob_lin, oob_swz;

    always_comb begin
        stride     = eff_stride(rsrc_i);
        idx        = CALC_W'(vidx_i) + (rsrc_i.tid_en ? CALC_W'(lane_i) : '0);
        off        = CALC_W'(voff_i) + CALC_W'(imm_i);
        start_addr = CALC_W'(rsrc_i.base) + CALC_W'(soff_i);

        // linear form and its bound
        lin_term = off + stride * idx;
        limit    = (rsrc_i.nrec > soff_i) ? CALC_W'(rsrc_i.nrec - soff_i) : '0;
        oob_lin  = (lin_term >= limit);

        // swizzled form: power-of-two split by shift and mask
        ish       = 3'd3 + {1'b0, rsrc_i.istr_code};
        esh       = rsrc_i.esz_code;
        idx_mask  = (CALC_W'(1) << ish) - 1'b1;
        off_mask  = (CALC_W'(2) << esh) - 1'b1;
        idx_hi    = idx >> ish;
        idx_lo    = idx & idx_mask;
        off_lo    = off & off_mask;
        off_hi_al = off & ~off_mask;
        swz_term  = ((idx_hi * stride + off_hi_al) << ish)
                  + ((idx_lo << esh) << 1) + off_lo;
        oob_swz   = (idx >= CALC_W'(rsrc_i.nrec)) || (off >= stride);

        res_o.addr = start_addr + (rsrc_i.swz_en ? swz_term : lin_term);
        res_o.oob  = (rsrc_i.swz_en && stride != '0) ? oob_swz : oob_lin;
    end
endmodule

// File: rtl/lane_addr_gen.sv
module lane_addr_gen
    import lag_pkg::*;
#(
    parameter int LANES  = 64,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [BASE_W-1:0]         base_i,
    input  logic [STRIDE_W-1:0]       stride_i,
    input  logic [NREC_W-1:0]         nrec_i,
    input  logic                      tid_en_i,
    input  logic [DFMT_W-1:0]         dfmt_i,
    input  logic                      swz_en_i,
    input  logic [1:0]                istr_code_i,
    input  logic [1:0]                esz_code_i,
    input  logic [WORD_W-1:0]         soff_i,
    input  logic [IMM_W-1:0]          inst_off_i,
    input  logic [LANES*WORD_W-1:0]   vec_off_i,
    input  logic [LANES*WORD_W-1:0]   vec_idx_i,
    input  logic [LANES-1:0]          exec_mask_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      addr_valid_o,
    output logic [LANE_W-1:0]         addr_lane_o,
    output logic [CALC_W-1:0]         addr_o,
    output logic [LANES-1:0]          oob_mask_o,
    output logic [LANES-1:0]          eff_mask_o
);
    rsrc_t             rsrc;
    lane_res_t         res;
    logic [LANE_W-1:0] lane;
    logic              lane_act;

    assign rsrc = '{base: base_i, stride: stride_i, nrec: nrec_i,
                    tid_en: tid_en_i, dfmt: dfmt_i, swz_en: swz_en_i,
                    istr_code: istr_code_i, esz_code: esz_code_i};

    lag_seq #(.LANES(LANES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .busy_o  (busy_o),
        .lane_o  (lane),
        .done_o  (done_o)
    );

    lag_lane_calc #(.LANES(LANES)) u_calc (
        .rsrc_i (rsrc),
        .lane_i (lane),
        .voff_i (vec_off_i[lane*WORD_W +: WORD_W]),
        .vidx_i (vec_idx_i[lane*WORD_W +: WORD_W]),
        .soff_i (soff_i),
        .imm_i  (inst_off_i),
        .res_o  (res)
    );

    assign lane_act = busy_o && exec_mask_i[lane];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_valid_o <= 1'b0;
            addr_lane_o  <= '0;
            addr_o       <= '0;
            oob_mask_o   <= '0;
        end else begin
            addr_valid_o <= lane_act;
            addr_lane_o  <= lane;
            addr_o       <= lane_act ? res.addr : '0;
            if (!busy_o && start_i)
                oob_mask_o <= '0;
            else if (lane_act && res.oob)
                oob_mask_o[lane] <= 1'b1;
        end
    end

    assign eff_mask_o = exec_mask_i & ~oob_mask_o;
endmodule

// File: rtl/lag_chk.sv
module lag_chk #(
    parameter int LANES  = 64,
    localparam int LANE_W = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [LANES-1:0]  exec_mask_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              addr_valid_o,
    input logic [LANE_W-1:0] addr_lane_o,
    input logic [LANES-1:0]  oob_mask_o
);
    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2
    busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    // R11
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R9
    valid_exec_chk: assert property (@(posedge clk) disable iff (rst)
        addr_valid_o |-> exec_mask_i[addr_lane_o]);

    // R9
    oob_in_exec_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((oob_mask_o & ~exec_mask_i) == '0));
endmodule

bind lane_addr_gen lag_chk #(.LANES(LANES)) u_lag_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .exec_mask_i  (exec_mask_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .addr_valid_o (addr_valid_o),
    .addr_lane_o  (addr_lane_o),
    .oob_mask_o   (oob_mask_o)
);

// File: tb/lane_addr_gen_bench.sv
module lane_addr_gen_bench;
    localparam int L = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          start = 1'b0;
    logic [47:0]   base = '0;
    logic [13:0]   stride = '0;
    logic [31:0]   nrec = '0;
    logic          tid = 1'b0;
    logic [3:0]    dfmt = '0;
    logic          swz = 1'b0;
    logic [1:0]    icode = '0;
    logic [1:0]    ecode = '0;
    logic [31:0]   soff = '0;
    logic [11:0]   imm = '0;
    logic [L*32-1:0] voff = '0;
    logic [L*32-1:0] vidx = '0;
    logic [L-1:0]  exec = '0;

    logic          busy, done, valid;
    logic [5:0]    lane;
    logic [63:0]   addr;
    logic [L-1:0]  oob, eff;

    lane_addr_gen u_lane_addr_gen (
        .clk(clk), .rst(rst), .start_i(start), .base_i(base), .stride_i(stride),
        .nrec_i(nrec), .tid_en_i(tid), .dfmt_i(dfmt), .swz_en_i(swz),
        .istr_code_i(icode), .esz_code_i(ecode), .soff_i(soff), .inst_off_i(imm),
        .vec_off_i(voff), .vec_idx_i(vidx), .exec_mask_i(exec),
        .busy_o(busy), .done_o(done), .addr_valid_o(valid), .addr_lane_o(lane),
        .addr_o(addr), .oob_mask_o(oob), .eff_mask_o(eff)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input string tag, input bit ok,
                       input longint unsigned act, input longint unsigned exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference of one lane
    function automatic void ref_lane(input int l, output bit o,
                                     output longint unsigned a);
        longint unsigned st, ix, of, ist, es, term, lim;
        st  = tid ? ((longint'(dfmt) << 14) + stride) : longint'(stride);
        ix  = longint'(vidx[l*32 +: 32]) + (tid ? l : 0);
        of  = longint'(voff[l*32 +: 32]) + imm;
        ist = 8 << icode;
        es  = 2 << ecode;
        if (swz)
            term = ((ix / ist) * st + (of / es) * es) * ist + (ix % ist) * es + (of % es);
        else
            term = of + st * ix;
        a = longint'(base) + soff + term;
        if (swz && st != 0)
            o = (ix >= nrec) || (of >= st);
        else begin
            lim = (nrec > soff) ? longint'(nrec - soff) : 0;
            o = ((of + st * ix) >= lim);
        end
    endfunction

    // cycle model
    bit m_busy, m_done, m_valid;
    int m_k;
    int m_lane;
    longint unsigned m_addr;
    logic [L-1:0] m_oob;

    always @(posedge clk) begin
        bit o;
        longint unsigned a;
        if (rst) begin
            m_busy = 0; m_done = 0; m_valid = 0; m_k = 0; m_addr = 0; m_oob = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                ref_lane(m_k, o, a);
                m_valid = exec[m_k];
                m_lane  = m_k;
                m_addr  = exec[m_k] ? a : 0;
                if (exec[m_k] && o) m_oob[m_k] = 1'b1;
                if (m_k == L - 1) begin m_busy = 0; m_done = 1; end
                else m_k++;
            end else begin
                m_valid = 0;
                m_addr  = 0;
                if (start) begin m_busy = 1; m_k = 0; m_oob = '0; end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            string at, ot;
            at = swz ? "R8 R3 R4" : "R5 R3 R4";
            ot = (swz && stride != 0) ? "R7" : "R6";
            chk("R2 R11 busy", busy == m_busy, busy, m_busy);
            chk("R2 done", done == m_done, done, m_done);
            chk("R9 valid", valid == m_valid, valid, m_valid);
            chk(at, addr == m_addr, addr, m_addr);
            if (m_valid) chk("R2 lane", lane == m_lane, lane, m_lane);
            chk(ot, oob == m_oob, oob, m_oob);
            if (m_done) chk("R10 eff", eff == (exec & ~m_oob), eff, exec & ~m_oob);
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic run_pass(input bit restart);
        pulse_start();
        if (restart) begin
            repeat (10) @(posedge clk);
            #1 start = 1'b1;            // R11 start while busy
            @(posedge clk); #1 start = 1'b0;
        end
        for (int i = 0; i < 200 && !done; i++) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 busy", busy == 0, busy, 0);
        chk("R1 done", done == 0, done, 0);
        chk("R1 valid", valid == 0, valid, 0);
        chk("R1 oob", oob == '0, oob, 0);
        @(posedge clk); #1;

        // linear, bound crossing
        base = 48'h1000_0000; stride = 16; nrec = 600; soff = 40; imm = 4;
        tid = 0; swz = 0; exec = '1;
        for (int l = 0; l < L; l++) begin
            voff[l*32 +: 32] = l * 3; vidx[l*32 +: 32] = l;
        end
        run_pass(0);

        // lane id folded, extended stride, sparse mask
        tid = 1; dfmt = 1; stride = 8; nrec = 32'hFFFF_FFFF; soff = 0; imm = 0;
        exec = 64'h5555_5555_5555_5555;
        for (int l = 0; l < L; l++) begin
            voff[l*32 +: 32] = l; vidx[l*32 +: 32] = 0;
        end
        run_pass(0);

        // swizzled with both bound conditions, restart while busy
        tid = 1; dfmt = 0; stride = 64; nrec = 40; swz = 1; icode = 1; ecode = 2;
        soff = 12; exec = 64'hFFFF_0000_FFFF_FFFF;
        for (int l = 0; l < L; l++) begin
            voff[l*32 +: 32] = (l * 5) % 80; vidx[l*32 +: 32] = l / 2;
        end
        run_pass(1);

        // zero stride with swizzle: linear bound rule
        tid = 0; stride = 0; nrec = 200; soff = 10; icode = 0; ecode = 0;
        exec = '1;
        for (int l = 0; l < L; l++) begin
            voff[l*32 +: 32] = l * 4; vidx[l*32 +: 32] = l;
        end
        run_pass(0);

        // scalar offset past record count
        swz = 0; stride = 4; nrec = 5; soff = 9; exec = 64'hF0F0_F0F0_F0F0_F0F0;
        run_pass(0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule